// File: doc/BRIEF.md
# Interval Timer with Shared Interrupt

This peripheral holds one or two independent timer channels behind a word-addressed register bus. Each channel has a control word, a load word and a readable counter. Software writes a start value into the load word. It then writes the control word with the run bit set, and from that moment the counter moves one step on every clock. When the counter reaches its terminal value the channel raises its expiry flag. With auto-reload set, the channel then restarts from the load word. Without it, the channel stops.

The bus decodes the channel from address bit 2 and the word inside the channel from bits 1:0. Reads are combinational and free of side effects. Writes take effect at the next clock edge. All channels share one level-sensitive interrupt output. A parameter sets the number of channels, and a one-channel build answers its absent channel with zeros.

Top module: `interval_timer`

## Requirements
- R1: After reset every readable word of every channel is zero and `irq` is low.
- R2: Control bits 10:0, except bit 8, are stored as written and read back as written. Bits above 10 read as zero. The load word (word 1) stores and returns the full 32-bit value.
- R3: A control write with bit 7 (run) set places the current load value in the counter at the next edge and starts counting. A control write with bit 7 clear stops the counter, which then holds its value.
- R4: A running counter moves by exactly one per clock. It counts down when control bit 1 is 1 and counts up when bit 1 is 0.
- R5: On the first edge at which a running counter already holds its terminal value (zero when counting down, all-ones when counting up), control bit 8 (expiry flag) becomes 1.
- R6: At that expiry edge the counter reloads from the load word and keeps running if control bit 4 (auto-reload) is 1. If bit 4 is 0, the counter stops and holds the terminal value.
- R7: Writing 1 to control bit 8 clears the flag, and writing 0 there leaves it unchanged. If a clearing write and an expiry fall on the same edge, the flag ends up set.
- R8: `irq` is high exactly when some present channel has both its flag and control bit 6 (interrupt enable) set.
- R9: Address bit 2 selects the channel. Bits 1:0 select the word: 0 is control, 1 is load, 2 is counter. Activity on one channel leaves the other channel unchanged.
- R10: Writes to the counter word (word 2) and to word 3 are ignored, and word 3 always reads zero.
- R11: With one channel configured, the channel-1 window reads zero, ignores writes and never drives `irq`.
- R12: Control bits 0, 2, 3, 5, 9 and 10 are storage only and do not change the counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address: bit 2 is the channel, bits 1:0 are the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Shared level interrupt |

## Verification
The counting is tried in several forms:
- a short one-shot down count, which shows whether the counter stops and holds at the right edge;
- a down count with auto-reload, whose period exposes an off-by-one in the expiry edge;
- an up count from just below all-ones, which separates the two terminal values;
- the same count with the storage-only control bits set, to show that those bits change nothing.

Flag-clearing writes are placed at every phase of a short reload period, so that one of them lands on the expiry edge itself. Stop and restart writes in the middle of a run, and writes to the read-only and unused words, each compare the counter against a reference model. A second one-channel instance receives the same traffic, which shows that the absent window stays silent.

// File: rtl/itmr_pkg.sv
`timescale 1ns/1ps
package itmr_pkg;
   // control word field positions used by the counting logic
   localparam int B_DOWN    = 1;
   localparam int B_RELOAD  = 4;
   localparam int B_IRQ_EN  = 6;
   localparam int B_RUN     = 7;
   localparam int B_FLAG    = 8;
   localparam int CTRL_BITS = 11;

   typedef enum logic [1:0] {
      W_CTRL  = 2'd0,
      W_LOAD  = 2'd1,
      W_COUNT = 2'd2,
      W_SPARE = 2'd3
   } word_e;
endpackage

// File: rtl/itmr_channel.sv
`timescale 1ns/1ps
module itmr_channel
   import itmr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_load,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] load_o,
   output logic [DATA_W-1:0] cnt_o,
   output logic              run_o,
   output logic              flag_o,
   output logic              req_o
);
   localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
   localparam logic [DATA_W-1:0] KEEP_MASK =
      DATA_W'((1 << CTRL_BITS) - 1) & ~(ONE << B_FLAG);

   logic [DATA_W-1:0] ctrl_q, load_q, cnt_q;
   logic              run_q, flag_q;
   logic [DATA_W-1:0] terminal;
   logic              at_term, expire;

   assign terminal = ctrl_q[B_DOWN] ? '0 : '1;
   assign at_term  = (cnt_q == terminal);
   assign expire   = run_q & at_term;

   // stored control bits and load word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata & KEEP_MASK;
         if (wr_load) load_q <= wdata;
      end
   end

   // counter and run state; a control write takes priority over counting
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (wr_ctrl) begin
         run_q <= wdata[B_RUN];
         if (wdata[B_RUN]) cnt_q <= load_q;
      end else if (run_q) begin
         if (at_term) begin
            if (ctrl_q[B_RELOAD]) cnt_q <= load_q;
            else                  run_q <= 1'b0;
         end else if (ctrl_q[B_DOWN]) begin
            cnt_q <= cnt_q - ONE;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   // expiry flag: set wins over a same-edge clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q <= 1'b0;
      else if (expire)                     flag_q <= 1'b1;
      else if (wr_ctrl && wdata[B_FLAG])   flag_q <= 1'b0;
   end

   assign ctrl_o = ctrl_q | (DATA_W'(flag_q) << B_FLAG);
   assign load_o = load_q;
   assign cnt_o  = cnt_q;
   assign run_o  = run_q;
   assign flag_o = flag_q;
   assign req_o  = flag_q & ctrl_q[B_IRQ_EN];
endmodule

// File: rtl/itmr_decode.sv
`timescale 1ns/1ps
module itmr_decode
   import itmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic                          bus_we,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_v,
   input  logic [NUM_CH-1:0][DATA_W-1:0] load_v,
   input  logic [NUM_CH-1:0][DATA_W-1:0] cnt_v,
   output logic [NUM_CH-1:0]             wr_ctrl,
   output logic [NUM_CH-1:0]             wr_load,
   output logic [DATA_W-1:0]             rdata
);
   localparam int CH_AW = ADDR_W - 2;

   logic [CH_AW-1:0] ch_idx;
   word_e            word;

   assign ch_idx = bus_addr[ADDR_W-1:2];
   assign word   = word_e'(bus_addr[1:0]);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
      assign wr_ctrl[g] = bus_we && (ch_idx == CH_AW'(g)) && (word == W_CTRL);
      assign wr_load[g] = bus_we && (ch_idx == CH_AW'(g)) && (word == W_LOAD);
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_idx == CH_AW'(i)) begin
            case (word)
               W_CTRL:  rdata = ctrl_v[i];
               W_LOAD:  rdata = load_v[i];
               W_COUNT: rdata = cnt_v[i];
               default: rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/itmr_irq_or.sv
`timescale 1ns/1ps
module itmr_irq_or #(
   parameter int NUM_CH = 2
) (
   input  logic [NUM_CH-1:0] req,
   output logic              irq
);
   if (NUM_CH == 1) begin : g_single
      assign irq = req[0];
   end else begin : g_multi
      assign irq = |req;
   end
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
   import itmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int ADDR_W = 3;

   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("interval_timer: NUM_CH must be 1 or 2");
   end
   if (DATA_W < CTRL_BITS) begin : g_bad_w
      $error("interval_timer: DATA_W too narrow for the control word");
   end

   logic [NUM_CH-1:0][DATA_W-1:0] ctrl_v, load_v, cnt_v;
   logic [NUM_CH-1:0]             wr_ctrl, wr_load, run_v, flag_v, req_v;

   itmr_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .ctrl_v   (ctrl_v),
      .load_v   (load_v),
      .cnt_v    (cnt_v),
      .wr_ctrl  (wr_ctrl),
      .wr_load  (wr_load),
      .rdata    (bus_rdata)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      itmr_channel #(.DATA_W(DATA_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ctrl (wr_ctrl[g]),
         .wr_load (wr_load[g]),
         .wdata   (bus_wdata),
         .ctrl_o  (ctrl_v[g]),
         .load_o  (load_v[g]),
         .cnt_o   (cnt_v[g]),
         .run_o   (run_v[g]),
         .flag_o  (flag_v[g]),
         .req_o   (req_v[g])
      );
   end

   itmr_irq_or #(.NUM_CH(NUM_CH)) u_irq (
      .req (req_v),
      .irq (irq)
   );
endmodule

// File: rtl/itmr_chk.sv
`timescale 1ns/1ps
module itmr_chk
   import itmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [2:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [DATA_W-1:0] ctrl0,
   input logic [DATA_W-1:0] load0,
   input logic [DATA_W-1:0] cnt0,
   input logic              run0,
   input logic [NUM_CH-1:0] flag_v
);
   logic              wr0;
   logic [DATA_W-1:0] term0;
   logic              at_term0;

   assign wr0      = bus_we && (bus_addr == 3'b000);
   assign term0    = ctrl0[B_DOWN] ? '0 : '1;
   assign at_term0 = (cnt0 == term0);

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && bus_wdata[B_RUN]) |=> (cnt0 == $past(load0)));

   // R4
   down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run0 && !at_term0 && ctrl0[B_DOWN] && !wr0) |=> (cnt0 == $past(cnt0) - DATA_W'(1)));

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run0 && at_term0) |=> flag_v[0]);

   // R6
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run0 && at_term0 && !ctrl0[B_RELOAD] && !wr0) |=> (!run0 && $stable(cnt0)));

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && bus_wdata[B_FLAG] && !(run0 && at_term0)) |=> !flag_v[0]);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v[0] && !(wr0 && bus_wdata[B_FLAG])) |=> flag_v[0]);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v == '0) |-> !irq);

   // R10
   spare_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] == 2'd3) |-> (bus_rdata == '0));
endmodule

bind interval_timer itmr_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .ctrl0     (ctrl_v[0]),
   .load0     (load_v[0]),
   .cnt0      (cnt_v[0]),
   .run0      (run_v[0]),
   .flag_v    (flag_v)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata2, rdata1;
   logic        irq2, irq1;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   interval_timer #(.NUM_CH(2), .DATA_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata2), .irq(irq2));

   interval_timer #(.NUM_CH(1), .DATA_W(32)) dut_one (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata1), .irq(irq1));

   // behavioural reference state, one entry per channel
   bit [31:0] m_cnt  [2];
   bit [31:0] m_load [2];
   bit [31:0] m_ctrl [2];
   bit        m_run  [2];
   bit        m_flag [2];

   function automatic bit [31:0] m_read(input bit [2:0] a, input int nch);
      int ch = a[2];
      if (ch >= nch) return 0;
      case (a[1:0])
         2'd0:    return m_ctrl[ch] | (32'(m_flag[ch]) << 8);
         2'd1:    return m_load[ch];
         2'd2:    return m_cnt[ch];
         default: return 0;
      endcase
   endfunction

   function automatic bit m_irq(input int nch);
      bit r = 0;
      for (int i = 0; i < nch; i++) r |= m_flag[i] & m_ctrl[i][6];
      return r;
   endfunction

   task automatic m_step(input bit we, input bit [2:0] a, input bit [31:0] d);
      for (int i = 0; i < 2; i++) begin
         bit wc = we && (a[2] == i) && (a[1:0] == 0);
         bit wl = we && (a[2] == i) && (a[1:0] == 1);
         bit [31:0] term = m_ctrl[i][1] ? 32'h0 : 32'hFFFF_FFFF;
         bit hit = m_run[i] && (m_cnt[i] == term);
         if (hit) m_flag[i] = 1;
         else if (wc && d[8]) m_flag[i] = 0;
         if (wc) begin
            m_run[i] = d[7];
            if (d[7]) m_cnt[i] = m_load[i];
         end else if (m_run[i]) begin
            if (hit) begin
               if (m_ctrl[i][4]) m_cnt[i] = m_load[i];
               else m_run[i] = 0;
            end else if (m_ctrl[i][1]) m_cnt[i] = m_cnt[i] - 1;
            else m_cnt[i] = m_cnt[i] + 1;
         end
         if (wc) m_ctrl[i] = d & 32'h0000_06FF;
         if (wl) m_load[i] = d;
      end
   endtask

   task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle: drive, compare both instances, clock, advance model
   task automatic cyc(input bit we, input bit [2:0] a, input bit [31:0] d, input string tag);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      check(tag, rdata2, m_read(a, 2));
      check("R8 irq", 32'(irq2), 32'(m_irq(2)));
      check(a[2] ? "R11 one-channel window" : tag, rdata1, m_read(a, 1));
      check("R11 one-channel irq", 32'(irq1), 32'(m_irq(1)));
      @(posedge clk);
      m_step(we, a, d);
   endtask

   task automatic wr(input bit [2:0] a, input bit [31:0] d, input string tag);
      cyc(1'b1, a, d, tag);
   endtask

   task automatic watch(input bit [2:0] a, input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(1'b0, a, 32'h0, tag);
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_cnt[i] = 0; m_load[i] = 0; m_ctrl[i] = 0; m_run[i] = 0; m_flag[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every word
      for (int a = 0; a < 8; a++) cyc(1'b0, 3'(a), 32'h0, "R1 reset value");

      // R2, R12: control storage and load word
      wr(3'd0, 32'hFFFF_FE7F, "R2 ctrl write");
      watch(3'd0, 2, "R2 ctrl readback");
      wr(3'd1, 32'hA5A5_1234, "R2 load write");
      watch(3'd1, 2, "R2 load readback");
      wr(3'd0, 32'h0, "R2 ctrl clear");

      // R10: counter word and spare word ignore writes
      wr(3'd2, 32'h0000_0055, "R10 counter write");
      watch(3'd2, 2, "R10 counter unchanged");
      wr(3'd3, 32'h0000_0077, "R10 spare write");
      watch(3'd3, 2, "R10 spare reads zero");

      // R3 R4 R5 R6: one-shot down count from 5 with interrupt enabled
      wr(3'd1, 32'd5, "R3 load");
      wr(3'd0, 32'h0000_00C2, "R3 start");
      watch(3'd2, 9, "R4 down count");
      watch(3'd0, 2, "R5 flag set");
      watch(3'd2, 3, "R6 one-shot holds");

      // R7: write 0 keeps the flag, write 1 clears it
      wr(3'd0, 32'h0000_0042, "R7 zero keeps flag");
      watch(3'd0, 2, "R7 flag kept");
      wr(3'd0, 32'h0000_0142, "R7 clear");
      watch(3'd0, 2, "R7 flag cleared");

      // R6 R9: channel 1 auto-reload down count, channel 0 stays put
      wr(3'd5, 32'd3, "R9 ch1 load");
      wr(3'd4, 32'h0000_00D2, "R6 ch1 start reload");
      watch(3'd6, 14, "R6 reload count");
      watch(3'd2, 2, "R9 ch0 unaffected");
      watch(3'd4, 2, "R5 ch1 flag");

      // R7: clearing writes at every phase of the reload period
      for (int k = 0; k < 6; k++) begin
         watch(3'd6, k, "R7 race phase");
         wr(3'd4, 32'h0000_01D0 | 32'h2, "R7 clear vs expiry");
         watch(3'd4, 1, "R7 race flag");
      end

      // R3: restart channel 1 mid-run, then halt it
      watch(3'd6, 2, "R3 running");
      wr(3'd4, 32'h0000_00D2, "R3 restart");
      watch(3'd6, 2, "R3 restarted count");
      wr(3'd4, 32'h0000_0100, "R3 halt");
      watch(3'd6, 3, "R3 halted holds");

      // R4 R5 R6: channel 0 up count with reload near all-ones
      wr(3'd0, 32'h0000_0100, "R7 ch0 clear");
      wr(3'd1, 32'hFFFF_FFFC, "R4 up load");
      wr(3'd0, 32'h0000_00D0, "R4 up start");
      watch(3'd2, 12, "R4 up count");
      watch(3'd0, 2, "R5 up flag");
      wr(3'd0, 32'h0000_0100, "R3 up stop");

      // R12: storage-only bits leave the down count unchanged
      wr(3'd1, 32'd4, "R12 load");
      wr(3'd0, 32'h0000_06AF, "R12 start with extra bits");
      watch(3'd2, 8, "R12 count");
      watch(3'd0, 2, "R12 ctrl readback");

      // R8: interrupt enable gates the shared line
      wr(3'd0, 32'h0000_0000, "R8 mask ch0");
      watch(3'd0, 2, "R8 masked");
      wr(3'd0, 32'h0000_0040, "R8 unmask ch0");
      watch(3'd0, 2, "R8 unmasked");
      wr(3'd0, 32'h0000_0100, "R8 clear ch0");
      wr(3'd4, 32'h0000_0100, "R8 clear ch1");
      watch(3'd0, 2, "R8 quiet");

      // R11: full sweep of the channel-1 window
      for (int a = 4; a < 8; a++) cyc(1'b0, 3'(a), 32'h0, "R11 sweep");

      finish_up();
   end
endmodule